// File: doc/BRIEF.md
# Channel-Select Register Bank With Update

This block holds the tuning and phase words for a four-channel waveform synthesizer and loads them through a single-bit serial port. A channel-select register holds one enable bit per channel. The tuning-word address and the phase-word address are shared by all channels, and a write to either one lands in the buffer of every channel whose enable bit is set. Software can therefore give every channel the same value in one transaction, or program the channels one at a time by changing the enable mask between writes.

Written values wait in buffer registers. They move to the active registers, which feed the datapath, when the update input rises. All channels change on the same system-clock edge. The enable mask works differently: it takes effect as soon as its byte is complete and needs no update.

The serial pins are oversampled by the system clock. The serial clock must therefore stay at each level for at least three system-clock cycles.

Top module: `chanRegBank`

## Requirements
- R1: A synchronous high level on `masterRst` clears every buffered and active tuning and phase word to zero, sets all four enable bits, and returns the serial port to waiting for an instruction byte.
- R2: A transaction is one instruction byte followed by data, both sent most significant bit first. Instruction bit 7 selects a read when 1 and a write when 0. Instruction bits 4:0 give the address. Address 0x00 takes 1 data byte, 0x04 takes 4 bytes and 0x05 takes 2 bytes. A write to any other address changes nothing.
- R3: When a write to address 0x00 completes, `chanEn` takes bits 3:0 of the data byte (bit i enables channel i) without waiting for an update. The upper four bits of the byte are ignored.
- R4: A write to 0x04 or 0x05 changes the buffer of every enabled channel and of no disabled channel. The active words on `tuneWords` and `phaseWords` do not change until an update.
- R5: On the system-clock edge that first samples `ioUpdate` high after it was low, every channel's buffered words are copied to its active words. If `ioUpdate` stays high, no further copy occurs until it goes low and rises again.
- R6: A read of 0x04 or 0x05 returns the buffered word of the lowest-numbered enabled channel, or zero if no channel is enabled. A read of 0x00 returns the enable mask in the low four bits. Read data is driven on `sdioOut` after each falling serial-clock edge and is valid at the next rising edge.
- R7: If `csN` rises before the last data bit of a write, the transaction is dropped and no register changes.
- R8: While `csN` is high, activity on `sclk` and `sdioIn` has no effect and `sdioOut` is held low.
- R9: The phase word is 14 bits. The two most significant bits of its 16-bit data field are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock; samples the serial pins and the update input |
| masterRst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock; data is captured on its rising edge |
| csN | input | 1 | Chip select, active low |
| sdioIn | input | 1 | Serial data into the block |
| sdioOut | output | 1 | Serial read data out of the block |
| ioUpdate | input | 1 | Rising edge copies the buffers to the active registers |
| chanEn | output | 4 | Channel enable mask; bit i controls channel i |
| tuneWords | output | 128 | Active tuning words; channel i uses bits 32i+31:32i |
| phaseWords | output | 56 | Active phase words; channel i uses bits 14i+13:14i |

## Verification
The bound checker checks these properties on every cycle:
- Active words never change except right after a sampled rising edge of the update input.
- The enable mask reads all ones right after reset.
- While chip select is high, the enable mask is stable and the serial output is low.

Only the bench's scenarios can show the rest:
- Writes are routed to the enabled channels alone.
- A read picks the lowest enabled channel.
- A transaction cut short by chip select leaves no trace.
- The upper bits of the phase field are dropped.
- A level held on the update input does not copy twice.

// File: rtl/chanbank_pkg.sv
package chanbank_pkg;
  localparam int DATA_W = 32;
  localparam logic [4:0] ADDR_SEL   = 5'h00;
  localparam logic [4:0] ADDR_TUNE  = 5'h04;
  localparam logic [4:0] ADDR_PHASE = 5'h05;

  // strobes from the serial control to the register datapath
  typedef struct packed {
    logic              wrSel;
    logic              wrTune;
    logic              wrPhase;
    logic [DATA_W-1:0] wrData;
  } bankCmd_t;

  // number of data bits that follow the instruction byte
  function automatic logic [5:0] dataBits(input logic [4:0] addr);
    case (addr)
      ADDR_SEL:   return 6'd8;
      ADDR_TUNE:  return 6'd32;
      ADDR_PHASE: return 6'd16;
      default:    return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/chanbank_serial.sv
module chanbank_serial
  import chanbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rdWord,
  output logic [4:0]        rdAddr,
  output bankCmd_t          cmd,
  output logic              sdo
);
  logic sclkQ, sclkPrev, csnQ, sdiQ;
  logic [5:0] bitCnt;
  logic [DATA_W-1:0] shiftReg, txReg;
  logic isRead, done, rdLoaded;
  logic [4:0] addrQ;
  logic rise, fall, instrDone, commitNow;
  logic [DATA_W-1:0] nextShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ <= 1'b0; sclkPrev <= 1'b0; csnQ <= 1'b1; sdiQ <= 1'b0;
    end else begin
      sclkQ <= sclk; sclkPrev <= sclkQ; csnQ <= csN; sdiQ <= sdi;
    end
  end

  always_comb begin
    rise      = sclkQ && !sclkPrev;
    fall      = !sclkQ && sclkPrev;
    nextShift = {shiftReg[DATA_W-2:0], sdiQ};
    instrDone = rise && (bitCnt == 6'd7);
    commitNow = rise && !done && !isRead && (bitCnt >= 6'd8) &&
                (bitCnt == 6'd7 + dataBits(addrQ));
    cmd.wrSel   = commitNow && (addrQ == ADDR_SEL);
    cmd.wrTune  = commitNow && (addrQ == ADDR_TUNE);
    cmd.wrPhase = commitNow && (addrQ == ADDR_PHASE);
    cmd.wrData  = nextShift;
    rdAddr      = addrQ;
  end

  always_ff @(posedge clk) begin
    if (rst || csnQ) begin
      bitCnt <= '0; shiftReg <= '0; txReg <= '0; addrQ <= '0;
      isRead <= 1'b0; done <= 1'b0; rdLoaded <= 1'b0; sdo <= 1'b0;
    end else begin
      if (rise) begin
        shiftReg <= nextShift;
        if (bitCnt != 6'd63) bitCnt <= bitCnt + 6'd1;
        if (instrDone) begin
          isRead <= nextShift[7];
          addrQ  <= nextShift[4:0];
          if (dataBits(nextShift[4:0]) == 6'd0) done <= 1'b1;
        end
        if (commitNow) done <= 1'b1;
      end
      if (fall && isRead && !done) begin
        if (!rdLoaded) begin
          sdo      <= rdWord[DATA_W-1];
          txReg    <= {rdWord[DATA_W-2:0], 1'b0};
          rdLoaded <= 1'b1;
        end else begin
          sdo   <= txReg[DATA_W-1];
          txReg <= {txReg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/chanbank_regs.sv
module chanbank_regs
  import chanbank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bankCmd_t                  cmd,
  input  logic [4:0]                rdAddr,
  input  logic                      ioUpdate,
  output logic [NUM_CH-1:0]         chanEn,
  output logic [NUM_CH*TUNE_W-1:0]  tuneAct,
  output logic [NUM_CH*PHASE_W-1:0] phaseAct,
  output logic [DATA_W-1:0]         rdWord
);
  localparam int SEL_W = 8;
  logic updQ, updEdge;
  logic [TUNE_W-1:0]  tuneBuf  [NUM_CH];
  logic [PHASE_W-1:0] phaseBuf [NUM_CH];

  assign updEdge = ioUpdate && !updQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      updQ   <= 1'b0;
      chanEn <= '1;
    end else begin
      updQ <= ioUpdate;
      if (cmd.wrSel) chanEn <= cmd.wrData[NUM_CH-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        tuneBuf[ch]  <= '0;
        phaseBuf[ch] <= '0;
        tuneAct[ch*TUNE_W +: TUNE_W]    <= '0;
        phaseAct[ch*PHASE_W +: PHASE_W] <= '0;
      end else begin
        if (cmd.wrTune && chanEn[ch])  tuneBuf[ch]  <= cmd.wrData[TUNE_W-1:0];
        if (cmd.wrPhase && chanEn[ch]) phaseBuf[ch] <= cmd.wrData[PHASE_W-1:0];
        if (updEdge) begin
          tuneAct[ch*TUNE_W +: TUNE_W]    <= tuneBuf[ch];
          phaseAct[ch*PHASE_W +: PHASE_W] <= phaseBuf[ch];
        end
      end
    end
  end

  // read path: lowest-numbered enabled channel
  always_comb begin
    logic [TUNE_W-1:0]  pickTune;
    logic [PHASE_W-1:0] pickPhase;
    pickTune  = '0;
    pickPhase = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanEn[i]) begin
        pickTune  = tuneBuf[i];
        pickPhase = phaseBuf[i];
      end
    end
    case (rdAddr)
      ADDR_SEL:   rdWord = DATA_W'(chanEn) << (DATA_W - SEL_W);
      ADDR_TUNE:  rdWord = DATA_W'(pickTune) << (DATA_W - TUNE_W);
      ADDR_PHASE: rdWord = DATA_W'(pickPhase) << (DATA_W - 16);
      default:    rdWord = '0;
    endcase
  end
endmodule

// File: rtl/chanRegBank.sv
module chanRegBank
  import chanbank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 14
) (
  input  logic                      sysClk,
  input  logic                      masterRst,
  input  logic                      sclk,
  input  logic                      csN,
  input  logic                      sdioIn,
  output logic                      sdioOut,
  input  logic                      ioUpdate,
  output logic [NUM_CH-1:0]         chanEn,
  output logic [NUM_CH*TUNE_W-1:0]  tuneWords,
  output logic [NUM_CH*PHASE_W-1:0] phaseWords
);
  bankCmd_t cmd;
  logic [4:0] rdAddr;
  logic [DATA_W-1:0] rdWord;

  chanbank_serial u_serial (
    .clk(sysClk), .rst(masterRst), .sclk(sclk), .csN(csN), .sdi(sdioIn),
    .rdWord(rdWord), .rdAddr(rdAddr), .cmd(cmd), .sdo(sdioOut)
  );

  chanbank_regs #(.NUM_CH(NUM_CH), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_regs (
    .clk(sysClk), .rst(masterRst), .cmd(cmd), .rdAddr(rdAddr),
    .ioUpdate(ioUpdate), .chanEn(chanEn), .tuneAct(tuneWords),
    .phaseAct(phaseWords), .rdWord(rdWord)
  );
endmodule

// File: rtl/chanbank_checker.sv
module chanbank_checker #(
  parameter int NUM_CH  = 4,
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 14
) (
  input logic                      sysClk,
  input logic                      masterRst,
  input logic                      csN,
  input logic                      ioUpdate,
  input logic                      sdioOut,
  input logic [NUM_CH-1:0]         chanEn,
  input logic [NUM_CH*TUNE_W-1:0]  tuneWords,
  input logic [NUM_CH*PHASE_W-1:0] phaseWords
);
  logic updPrev;
  always_ff @(posedge sysClk) updPrev <= masterRst ? 1'b0 : ioUpdate;

  AST_TUNE_ONLY_ON_UPDATE: assert property (@(posedge sysClk) disable iff (masterRst)
    !$stable(tuneWords) |-> ($past(ioUpdate) && !$past(updPrev))); // R5
  AST_PHASE_ONLY_ON_UPDATE: assert property (@(posedge sysClk) disable iff (masterRst)
    !$stable(phaseWords) |-> ($past(ioUpdate) && !$past(updPrev))); // R4
  AST_ENABLES_AFTER_RESET: assert property (@(posedge sysClk) disable iff (masterRst)
    $fell(masterRst) |-> (&chanEn)); // R1
  AST_DESELECT_HOLDS_MASK: assert property (@(posedge sysClk) disable iff (masterRst)
    csN |-> ##2 $stable(chanEn)); // R8
  AST_DESELECT_SDO_LOW: assert property (@(posedge sysClk) disable iff (masterRst)
    csN |-> ##2 !sdioOut); // R8
endmodule

bind chanRegBank chanbank_checker #(.NUM_CH(NUM_CH), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_checker (
  .sysClk(sysClk), .masterRst(masterRst), .csN(csN), .ioUpdate(ioUpdate),
  .sdioOut(sdioOut), .chanEn(chanEn), .tuneWords(tuneWords), .phaseWords(phaseWords)
);

// File: tb/chanRegBank_bench.sv
module chanRegBank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NCH = 4;

  logic sysClk = 1'b0;
  logic masterRst = 1'b1;
  logic sclk = 1'b0, csN = 1'b1, sdioIn = 1'b0, ioUpdate = 1'b0;
  logic sdioOut;
  logic [NCH-1:0] chanEn;
  logic [NCH*32-1:0] tuneWords;
  logic [NCH*14-1:0] phaseWords;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [3:0]  mEn;
  logic [31:0] mTuneBuf [NCH];
  logic [13:0] mPhaseBuf [NCH];
  logic [31:0] mTuneAct [NCH];
  logic [13:0] mPhaseAct [NCH];

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  chanRegBank u_chanRegBank (
    .sysClk(sysClk), .masterRst(masterRst), .sclk(sclk), .csN(csN),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .ioUpdate(ioUpdate), .chanEn(chanEn),
    .tuneWords(tuneWords), .phaseWords(phaseWords)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [4:0] addr);
    for (int i = 0; i < NCH; i++)
      if (mEn[i]) return (addr == 5'h04) ? mTuneBuf[i] : {18'b0, mPhaseBuf[i]};
    return 32'h0;
  endfunction

  task automatic checkActive(input string req);
    for (int i = 0; i < NCH; i++) begin
      check(req, tuneWords[i*32 +: 32], mTuneAct[i]);
      check(req, {18'b0, phaseWords[i*14 +: 14]}, {18'b0, mPhaseAct[i]});
    end
    check(req, {28'b0, chanEn}, {28'b0, mEn});
  endtask

  task automatic clkBit(input logic b, output logic got);
    sdioIn = b; sclk = 1'b0;
    repeat (HALF) @(negedge sysClk);
    got = sdioOut;
    sclk = 1'b1;
    repeat (HALF) @(negedge sysClk);
  endtask

  // instruction byte, then nBits of data; cut < nBits aborts early
  task automatic xfer(input logic [7:0] instr, input logic [31:0] data,
                      input int nBits, input int cut, output logic [31:0] rd);
    logic got;
    rd = '0;
    csN = 1'b0;
    repeat (2) @(negedge sysClk);
    for (int i = 7; i >= 0; i--) clkBit(instr[i], got);
    for (int i = nBits - 1; i >= 0; i--) begin
      if (nBits - 1 - i >= cut) break;
      clkBit(data[i], got);
      rd = {rd[30:0], got};
    end
    sclk = 1'b0; csN = 1'b1;
    repeat (4) @(negedge sysClk);
  endtask

  task automatic wrSel(input logic [7:0] v);
    logic [31:0] rd;
    xfer(8'h00, {24'b0, v}, 8, 99, rd);
    mEn = v[3:0];
  endtask

  task automatic wrTune(input logic [31:0] v);
    logic [31:0] rd;
    xfer(8'h04, v, 32, 99, rd);
    for (int i = 0; i < NCH; i++) if (mEn[i]) mTuneBuf[i] = v;
  endtask

  task automatic wrPhase(input logic [15:0] v);
    logic [31:0] rd;
    xfer(8'h05, {16'b0, v}, 16, 99, rd);
    for (int i = 0; i < NCH; i++) if (mEn[i]) mPhaseBuf[i] = v[13:0];
  endtask

  task automatic pulseUpdate();
    ioUpdate = 1'b1;
    repeat (2) @(negedge sysClk);
    ioUpdate = 1'b0;
    repeat (2) @(negedge sysClk);
    for (int i = 0; i < NCH; i++) begin
      mTuneAct[i] = mTuneBuf[i];
      mPhaseAct[i] = mPhaseBuf[i];
    end
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic got;
    void'($urandom(32'd4242));
    mEn = 4'hF;
    for (int i = 0; i < NCH; i++) begin
      mTuneBuf[i] = '0; mPhaseBuf[i] = '0; mTuneAct[i] = '0; mPhaseAct[i] = '0;
    end
    repeat (5) @(negedge sysClk);
    masterRst = 1'b0;
    repeat (2) @(negedge sysClk);

    // R1: reset state
    checkActive("R1 reset state");
    xfer(8'h84, 32'h0, 32, 99, rd);
    check("R1 reset buffer read", rd, 32'h0);

    // R4: shared write reaches all enabled channels, active waits
    wrTune(32'h1234_5678);
    checkActive("R4 active held before update");
    xfer(8'h84, 32'h0, 32, 99, rd);
    check("R6 read buffered tune", rd, 32'h1234_5678);
    pulseUpdate();
    checkActive("R5 update copies all channels");

    // R3: mask immediate; per-channel programming; R9 phase top bits
    wrSel(8'hF1);
    check("R3 mask immediate, upper bits ignored", {28'b0, chanEn}, 32'h1);
    wrTune(32'hAAAA_0001); wrPhase(16'hFFFF);
    wrSel(8'h02); wrTune(32'hBBBB_0002); wrPhase(16'h1234);
    wrSel(8'h04); wrTune(32'hCCCC_0003);
    wrSel(8'h08); wrPhase(16'h4001);
    checkActive("R4 disabled and buffered words stay off outputs");
    pulseUpdate();
    checkActive("R5 R9 per-channel values after update");

    // R6: read lowest enabled, none enabled, mask read
    wrSel(8'h06);
    xfer(8'h84, 32'h0, 32, 99, rd);
    check("R6 lowest enabled tune", rd, expRead(5'h04));
    xfer(8'h85, 32'h0, 16, 99, rd);
    check("R6 lowest enabled phase", rd, expRead(5'h05));
    xfer(8'h80, 32'h0, 8, 99, rd);
    check("R6 mask read", rd, 32'h06);
    wrSel(8'h00);
    xfer(8'h84, 32'h0, 32, 99, rd);
    check("R6 no channel enabled", rd, 32'h0);

    // R7: aborted writes
    wrSel(8'h0F);
    xfer(8'h04, 32'hDEAD_BEEF, 32, 20, rd);
    xfer(8'h00, 32'h0000_0003, 8, 5, rd);
    check("R7 mask unchanged after abort", {28'b0, chanEn}, 32'hF);
    pulseUpdate();
    checkActive("R7 aborted tune write dropped");

    // R2: unknown address ignored
    xfer(8'h07, 32'h0000_0055, 8, 99, rd);
    pulseUpdate();
    checkActive("R2 unknown address ignored");

    // R8: bus ignored while deselected
    for (int i = 0; i < 24; i++) begin
      clkBit(1'b1, got);
      check("R8 sdioOut low while deselected", {31'b0, got}, 32'h0);
    end
    pulseUpdate();
    checkActive("R8 deselected traffic has no effect");

    // R5: held-high update does not recopy
    ioUpdate = 1'b1;
    repeat (2) @(negedge sysClk);
    wrTune(32'h0F0F_F0F0);
    checkActive("R5 level high does not copy again");
    ioUpdate = 1'b0;
    repeat (2) @(negedge sysClk);
    pulseUpdate();
    checkActive("R5 new rising edge copies");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: wrSel({4'($urandom), 4'($urandom)});
        1: wrTune($urandom);
        2: wrPhase(16'($urandom));
        3: begin
          xfer(8'h84, 32'h0, 32, 99, rd);
          check("R6 random tune read", rd, expRead(5'h04));
        end
        default: begin
          pulseUpdate();
          checkActive("R4 R5 random update");
        end
      endcase
    end
    pulseUpdate();
    checkActive("R5 final update");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule